// File: doc/BRIEF.md
# Serial Command Front-End for a Word RAM

This block is the slave side of a four-wire serial link (chip enable, serial clock, data in, data out) that gives a host access to a small word-organised RAM. The host raises chip enable and shifts in a command frame. The frame opens with a single 1 bit. Four address bits come next, and a three-bit opcode closes it. A write opcode is followed by one data word shifted in. A read opcode makes the block drive one data word back out. The remaining opcodes are mode commands. The block does not act on these itself. It passes each one to a separate protection controller as a single-cycle strobe.

All logic runs on a fast system clock. The serial clock, chip enable and data input are treated as synchronous inputs. Serial clock edges are found by comparing the input with a registered copy of it. Input bits are taken on rising serial-clock edges. The first read bit is launched on the falling edge that closes the command. The protection controller returns a write-permission level, and RAM writes take effect only while that level is high. The data output comes with an enable, so a pad can build a tri-state pin from it. Data in and data out may also share one wire, because the last command bit of a read is ignored.

Top module: `serial_word_ram`

## Requirements
- R1: During and after a synchronous reset, `sdo_en`, `sdo` and all four command strobes are low.
- R2: While chip enable is high and no frame has begun, 0 bits sampled on rising serial-clock edges are skipped. The first 1 sampled is the start bit.
- R3: After the start bit, the four address bits come first, most significant first, and the three opcode bits follow. On the 8th rising edge, opcode 100 pulses `cmd_wren`, 000 pulses `cmd_wrds`, 001 pulses `cmd_store` and 101 pulses `cmd_recall`. Each pulse lasts one system cycle, and the address bits are ignored for these opcodes. Opcode 010 pulses nothing.
- R4: Opcode 011 takes the next 16 sampled bits as a data word, first bit into word bit 15. If the write is permitted, the word replaces the addressed RAM word.
- R5: If `wr_allow` is low when the 16th data bit is sampled, the RAM is left unchanged.
- R6: An opcode whose first two bits are 11 is a read, and its third bit is ignored. On the falling serial-clock edge after the 8th rising edge, `sdo_en` rises and `sdo` shows word bit 15. Each of the next 15 rising edges moves `sdo` to the next lower bit.
- R7: `sdo_en` is low at all times except during a read transfer. It falls on the 16th rising edge after the read command, even if chip enable stays high.
- R8: If chip enable falls before the 8th command bit, no strobe or RAM access results, and the partial frame is cleared. The next frame decodes normally.
- R9: A write frame that ends with fewer than 16 data bits leaves the RAM unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Chip enable, high for the length of a frame |
| sclk | input | 1 | Serial clock level, sampled by clk |
| sdi | input | 1 | Serial data in |
| wr_allow | input | 1 | Write permission from the protection controller |
| sdo | output | 1 | Serial data out |
| sdo_en | output | 1 | Output enable for sdo (low means high impedance) |
| cmd_wren | output | 1 | One-cycle strobe: enable-writes command |
| cmd_wrds | output | 1 | One-cycle strobe: disable-writes command |
| cmd_store | output | 1 | One-cycle strobe: store command |
| cmd_recall | output | 1 | One-cycle strobe: recall command |

## Verification
Most internal faults show up at the pins within a single frame. A bad bit counter or header register gives a wrong strobe or a word at the wrong address. The strobe appears within one system cycle of the 8th rising edge. The bad word is seen in the next read back. If the abort does not clear the frame, the frame after a dropped chip enable is decoded wrongly. A wrong launch point moves every read bit by one serial clock, so the first word read back differs from the expected word in every shifted position. `sdo_en` is checked just before and just after the falling edge that should launch the read, and again after the last bit.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_WDATA,
    ST_RWAIT,
    ST_RDATA,
    ST_DONE
  } sfe_state_e;

  localparam logic [2:0] OP_WRDS   = 3'b000;
  localparam logic [2:0] OP_STORE  = 3'b001;
  localparam logic [2:0] OP_WRITE  = 3'b011;
  localparam logic [2:0] OP_WREN   = 3'b100;
  localparam logic [2:0] OP_RECALL = 3'b101;

  typedef struct packed {
    logic wren;
    logic wrds;
    logic store;
    logic recall;
  } sfe_cmd_t;

endpackage

// File: rtl/sfe_edge.sv
module sfe_edge (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  output logic rise,
  output logic fall
);
  logic sclk_q;

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b0;
    else     sclk_q <= sclk;
  end

  assign rise = sclk & ~sclk_q;
  assign fall = ~sclk & sclk_q;
endmodule

// File: rtl/sfe_ram.sv
module sfe_ram #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/sfe_frame.sv
module sfe_frame
  import sfe_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int OP_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              sdi,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              wr_allow,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_waddr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              ram_re,
  output logic [ADDR_W-1:0] ram_raddr,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              sdo,
  output logic              sdo_en,
  output sfe_cmd_t          cmd
);
  localparam int HDR_BITS = ADDR_W + OP_W;
  localparam int MAX_CNT  = (DATA_W > HDR_BITS) ? DATA_W : HDR_BITS;
  localparam int CNT_W    = $clog2(MAX_CNT);

  sfe_state_e        state;
  logic [HDR_BITS-2:0] hdr_q;
  logic [HDR_BITS-1:0] hdr_next;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-2:0] wsh;
  logic [DATA_W-1:0] osh;
  logic [ADDR_W-1:0] addr_of;
  logic [OP_W-1:0]   op_of;
  logic              hdr_last;
  logic              data_last;
  logic              is_read;

  assign hdr_next  = {hdr_q, sdi};
  assign addr_of   = hdr_next[HDR_BITS-1 -: ADDR_W];
  assign op_of     = hdr_next[OP_W-1:0];
  assign hdr_last  = (cnt == CNT_W'(HDR_BITS - 1));
  assign data_last = (cnt == CNT_W'(DATA_W - 1));
  assign is_read   = (op_of[OP_W-1 -: 2] == 2'b11);

  // Read port is driven directly so the word is ready one cycle after the 8th rise
  assign ram_re    = (state == ST_HDR) && ce && sclk_rise && hdr_last && is_read;
  assign ram_raddr = addr_of;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      hdr_q     <= '0;
      cnt       <= '0;
      addr_q    <= '0;
      wsh       <= '0;
      osh       <= '0;
      sdo       <= 1'b0;
      sdo_en    <= 1'b0;
      cmd       <= '0;
      ram_we    <= 1'b0;
      ram_waddr <= '0;
      ram_wdata <= '0;
    end else begin
      cmd    <= '0;
      ram_we <= 1'b0;
      if (!ce) begin
        // R8: deselect clears every partial frame
        state  <= ST_IDLE;
        hdr_q  <= '0;
        cnt    <= '0;
        wsh    <= '0;
        sdo    <= 1'b0;
        sdo_en <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (sclk_rise && sdi) begin
              state <= ST_HDR;
              cnt   <= '0;
              hdr_q <= '0;
            end
          end
          ST_HDR: begin
            if (sclk_rise) begin
              hdr_q <= hdr_next[HDR_BITS-2:0];
              cnt   <= cnt + 1'b1;
              if (hdr_last) begin
                addr_q <= addr_of;
                cnt    <= '0;
                if (is_read) begin
                  state <= ST_RWAIT;
                end else if (op_of == OP_WRITE) begin
                  state <= ST_WDATA;
                end else begin
                  cmd.wren   <= (op_of == OP_WREN);
                  cmd.wrds   <= (op_of == OP_WRDS);
                  cmd.store  <= (op_of == OP_STORE);
                  cmd.recall <= (op_of == OP_RECALL);
                  state      <= ST_DONE;
                end
              end
            end
          end
          ST_WDATA: begin
            if (sclk_rise) begin
              wsh <= {wsh[DATA_W-3:0], sdi};
              cnt <= cnt + 1'b1;
              if (data_last) begin
                ram_we    <= wr_allow;
                ram_wdata <= {wsh, sdi};
                ram_waddr <= addr_q;
                state     <= ST_DONE;
              end
            end
          end
          ST_RWAIT: begin
            if (sclk_fall) begin
              osh    <= ram_rdata;
              sdo    <= ram_rdata[DATA_W-1];
              sdo_en <= 1'b1;
              cnt    <= '0;
              state  <= ST_RDATA;
            end
          end
          ST_RDATA: begin
            if (sclk_rise) begin
              if (data_last) begin
                sdo    <= 1'b0;
                sdo_en <= 1'b0;
                state  <= ST_DONE;
              end else begin
                osh <= osh << 1;
                sdo <= osh[DATA_W-2];
                cnt <= cnt + 1'b1;
              end
            end
          end
          ST_DONE: ;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  p_one_cmd_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd.wren, cmd.wrds, cmd.store, cmd.recall}));

  p_strobe_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    (|cmd) |=> !(|cmd));

  p_hiz_on_deselect_r8: assert property (@(posedge clk) disable iff (rst)
    !ce |=> !sdo_en);

  p_launch_on_fall_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(sdo_en) |-> $past(sclk_fall));
endmodule

// File: rtl/serial_word_ram.sv
module serial_word_ram
  import sfe_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic ce,
  input  logic sclk,
  input  logic sdi,
  input  logic wr_allow,
  output logic sdo,
  output logic sdo_en,
  output logic cmd_wren,
  output logic cmd_wrds,
  output logic cmd_store,
  output logic cmd_recall
);
  logic              rise, fall;
  logic              ram_we, ram_re;
  logic [ADDR_W-1:0] ram_waddr, ram_raddr;
  logic [DATA_W-1:0] ram_wdata, ram_rdata;
  sfe_cmd_t          cmd;

  sfe_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .sclk (sclk),
    .rise (rise),
    .fall (fall)
  );

  sfe_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OP_W(3)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .ce        (ce),
    .sdi       (sdi),
    .sclk_rise (rise),
    .sclk_fall (fall),
    .wr_allow  (wr_allow),
    .ram_we    (ram_we),
    .ram_waddr (ram_waddr),
    .ram_wdata (ram_wdata),
    .ram_re    (ram_re),
    .ram_raddr (ram_raddr),
    .ram_rdata (ram_rdata),
    .sdo       (sdo),
    .sdo_en    (sdo_en),
    .cmd       (cmd)
  );

  sfe_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .re    (ram_re),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

  assign cmd_wren   = cmd.wren;
  assign cmd_wrds   = cmd.wrds;
  assign cmd_store  = cmd.store;
  assign cmd_recall = cmd.recall;

  p_we_gated_r5: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> $past(wr_allow));
endmodule

// File: tb/tb_serial_word_ram.sv
module tb_serial_word_ram;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 3;

  logic clk = 1'b0;
  logic rst, ce, sclk, sdi, wr_allow;
  logic sdo, sdo_en, cmd_wren, cmd_wrds, cmd_store, cmd_recall;

  serial_word_ram dut (
    .clk(clk), .rst(rst), .ce(ce), .sclk(sclk), .sdi(sdi), .wr_allow(wr_allow),
    .sdo(sdo), .sdo_en(sdo_en), .cmd_wren(cmd_wren), .cmd_wrds(cmd_wrds),
    .cmd_store(cmd_store), .cmd_recall(cmd_recall)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0;
  int n_fail = 0;
  int c_wren = 0, c_wrds = 0, c_store = 0, c_recall = 0;
  logic [15:0] exp_q[$];
  logic [15:0] rbuf = '0;
  int rbits = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // strobe monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (cmd_wren)   c_wren++;
      if (cmd_wrds)   c_wrds++;
      if (cmd_store)  c_store++;
      if (cmd_recall) c_recall++;
    end
  end

  // read-data monitor: scoreboard pop on every full word (R4, R6)
  always @(posedge sclk) begin
    if (sdo_en) begin
      rbuf = {rbuf[14:0], sdo};
      rbits++;
      if (rbits == 16) begin
        rbits = 0;
        if (exp_q.size() == 0) check(0, "R6 unexpected read word", rbuf, 16'h0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          check(rbuf === e, "R4/R6 read word", rbuf, e);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic b);
    sdi = b;
    tick(HALF);
    sclk = 1'b1;
    tick(HALF);
    sclk = 1'b0;
  endtask

  task automatic open_f();
    ce = 1'b1;
    tick(2);
  endtask

  task automatic close_f();
    tick(HALF);
    ce = 1'b0;
    tick(3);
  endtask

  task automatic hdr(input logic [3:0] a, input logic [2:0] op);
    pulse(1'b1);
    for (int i = 3; i >= 0; i--) pulse(a[i]);
    for (int i = 2; i >= 0; i--) pulse(op[i]);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    open_f();
    hdr(a, 3'b011);
    for (int i = 15; i >= 0; i--) pulse(d[i]);
    close_f();
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] e, input logic b8);
    exp_q.push_back(e);
    open_f();
    hdr(a, {2'b11, b8});
    for (int i = 0; i < 16; i++) pulse(i[0]);
    close_f();
  endtask

  task automatic mode(input logic [3:0] a, input logic [2:0] op);
    open_f();
    hdr(a, op);
    close_f();
  endtask

  task automatic check_strobes(input string req, input int w, input int d, input int s, input int r,
                               input int w0, input int d0, input int s0, input int r0);
    check((c_wren - w0) == w && (c_wrds - d0) == d && (c_store - s0) == s && (c_recall - r0) == r,
          req, 16'({c_wren - w0, c_wrds - d0, c_store - s0, c_recall - r0}),
          16'({w, d, s, r}));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int w0, d0, s0, r0;
    rst = 1'b1; ce = 1'b0; sclk = 1'b0; sdi = 1'b0; wr_allow = 1'b1;
    tick(5);
    // R1: reset state
    check(!sdo_en && !sdo && !cmd_wren && !cmd_wrds && !cmd_store && !cmd_recall,
          "R1 outputs in reset", 16'({sdo_en, sdo, cmd_wren, cmd_wrds, cmd_store, cmd_recall}), 16'h0);
    rst = 1'b0;
    tick(3);
    check(!sdo_en && !cmd_wren, "R1 outputs after reset", 16'({sdo_en, cmd_wren}), 16'h0);

    // R4: writes and reads, R6: eighth bit ignored either way
    wr(4'h3, 16'hA5C3);
    wr(4'hF, 16'h8001);
    wr(4'h0, 16'h7FFE);
    rd(4'h3, 16'hA5C3, 1'b0);
    rd(4'hF, 16'h8001, 1'b1);
    rd(4'h0, 16'h7FFE, 1'b1);

    // R3: mode strobes, address ignored
    w0 = c_wren; d0 = c_wrds; s0 = c_store; r0 = c_recall;
    mode(4'h5, 3'b100);
    check_strobes("R3 wren strobe", 1, 0, 0, 0, w0, d0, s0, r0);
    w0 = c_wren; d0 = c_wrds; s0 = c_store; r0 = c_recall;
    mode(4'hA, 3'b000);
    check_strobes("R3 wrds strobe", 0, 1, 0, 0, w0, d0, s0, r0);
    w0 = c_wren; d0 = c_wrds; s0 = c_store; r0 = c_recall;
    mode(4'h0, 3'b001);
    check_strobes("R3 store strobe", 0, 0, 1, 0, w0, d0, s0, r0);
    w0 = c_wren; d0 = c_wrds; s0 = c_store; r0 = c_recall;
    mode(4'hF, 3'b101);
    check_strobes("R3 recall strobe", 0, 0, 0, 1, w0, d0, s0, r0);
    w0 = c_wren; d0 = c_wrds; s0 = c_store; r0 = c_recall;
    mode(4'h3, 3'b010);
    check_strobes("R3 unused opcode", 0, 0, 0, 0, w0, d0, s0, r0);
    rd(4'h3, 16'hA5C3, 1'b0);

    // R5: write blocked without permission
    wr_allow = 1'b0;
    wr(4'h3, 16'h1234);
    wr_allow = 1'b1;
    rd(4'h3, 16'hA5C3, 1'b1);

    // R6/R7: launch timing of the first read bit
    exp_q.push_back(16'hA5C3);
    open_f();
    pulse(1'b1);
    pulse(1'b0); pulse(1'b0); pulse(1'b1); pulse(1'b1);
    pulse(1'b1); pulse(1'b1);
    sdi = 1'b0;
    tick(HALF);
    sclk = 1'b1;
    tick(HALF);
    check(sdo_en == 1'b0, "R7 sdo_en low before launching fall", 16'(sdo_en), 16'h0);
    sclk = 1'b0;
    tick(2);
    check(sdo_en == 1'b1 && sdo == 1'b1, "R6 bit15 driven after fall of clock 8",
          16'({sdo_en, sdo}), 16'h3);
    for (int i = 0; i < 16; i++) pulse(1'b0);
    tick(2);
    check(sdo_en == 1'b0, "R7 sdo_en low after last bit with ce high", 16'(sdo_en), 16'h0);
    close_f();

    // R2: leading zeros skipped; R7: no drive during a write
    open_f();
    pulse(1'b0); pulse(1'b0); pulse(1'b0);
    hdr(4'h9, 3'b011);
    for (int i = 15; i >= 0; i--) pulse(i[0] ? 1'b1 : 1'b0);
    tick(2);
    check(sdo_en == 1'b0, "R7 sdo_en low during write", 16'(sdo_en), 16'h0);
    close_f();
    rd(4'h9, 16'hAAAA, 1'b0);

    // R8: abort mid-header, no strobe, next frame clean
    w0 = c_wren; d0 = c_wrds; s0 = c_store; r0 = c_recall;
    open_f();
    pulse(1'b1);
    pulse(1'b1); pulse(1'b1); pulse(1'b1); pulse(1'b1);
    pulse(1'b1); pulse(1'b0);
    close_f();
    check_strobes("R8 aborted header gives no strobe", 0, 0, 0, 0, w0, d0, s0, r0);
    check(sdo_en == 1'b0, "R8 no output after abort", 16'(sdo_en), 16'h0);
    rd(4'h0, 16'h7FFE, 1'b0);

    // R9: short write discarded
    open_f();
    hdr(4'h0, 3'b011);
    for (int i = 0; i < 10; i++) pulse(1'b1);
    close_f();
    rd(4'h0, 16'h7FFE, 1'b1);

    tick(5);
    check(exp_q.size() == 0, "R6 all expected reads observed", 16'(exp_q.size()), 16'h0);
    finish_run();
  end
endmodule